// File: doc/BRIEF.md
# Two-Voice Volume Mixer

The mixer takes the single-bit outputs of two tone voices and turns them into one 4-bit audio sample. One 6-bit volume register sets a 3-bit level for each voice. The register decoder loads it through a write strobe and a data bus. When a voice bit is high, that voice adds its level to the sum. When the bit is low, the voice adds nothing.

The sample is registered and drives the output pins directly, where an external DAC turns it into sound. Two levels of at most 7 give a sum of at most 14, so the 4-bit output never wraps or clips.

Top module: `duo_mixer`

## Requirements
- R1: While rst_ni is low, both volume fields read as 0 and sample_o is 0.
- R2: A cycle with wr_en_i high loads wr_data_i into the volume register at the rising clock edge. Bits [2:0] are the voice 0 level and bits [5:3] are the voice 1 level.
- R3: While wr_en_i is low, the volume register keeps its value whatever wr_data_i carries.
- R4: Each voice adds its level to the sum while its voice bit is 1 and adds 0 while the bit is 0. A level of 0 therefore silences that voice.
- R5: sample_o is the sum of the two voice contributions as an unsigned value, and it reaches 14 when both levels are 7 and both voice bits are 1.
- R6: sample_o is registered. It shows the sum formed from the voice bits and volume register of the previous clock edge, so it changes one cycle after a voice bit changes or a write happens.
- R7: sample_o never exceeds 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Volume register write strobe |
| wr_data_i | input | 6 | Volume data: [2:0] voice 0, [5:3] voice 1 |
| voice0_i | input | 1 | Voice 0 tone bit |
| voice1_i | input | 1 | Voice 1 tone bit |
| sample_o | output | 4 | Registered mixed sample |

## Verification
The assertions assume that the voice bits and the write strobe are synchronous to clk_i and stable around its rising edge. The bench changes every input only on the falling edge to meet that. The assertions also assume that no input is X after reset. The bench drives all inputs to known values before it releases rst_ni. The sample-update property compares sample_o with the registered inputs of the previous cycle. It holds only when there is no reset in between, so the bench asserts reset once, at the start.

// File: rtl/duo_mixer_pkg.sv
package duo_mixer_pkg;
  parameter int unsigned NUM_VOICES = 2;
  parameter int unsigned VOL_W      = 3;
  localparam int unsigned REG_W     = NUM_VOICES * VOL_W;
  localparam int unsigned MAX_SUM   = NUM_VOICES * ((1 << VOL_W) - 1);
  localparam int unsigned SAMPLE_W  = $clog2(MAX_SUM + 1);
endpackage

// File: rtl/duo_mixer_volreg.sv
module duo_mixer_volreg #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] vol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vol_o <= '0;
    else if (wr_en_i) vol_o <= wr_data_i;
  end
endmodule

// File: rtl/duo_mixer_gate.sv
module duo_mixer_gate #(
  parameter int unsigned VOL_W = 3
) (
  input  logic             tone_i,
  input  logic [VOL_W-1:0] vol_i,
  output logic [VOL_W-1:0] level_o
);
  assign level_o = tone_i ? vol_i : '0;
endmodule

// File: rtl/duo_mixer.sv
module duo_mixer
  import duo_mixer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [5:0] wr_data_i,
  input  logic       voice0_i,
  input  logic       voice1_i,
  output logic [3:0] sample_o
);
  logic [REG_W-1:0]      vol_q;
  logic [NUM_VOICES-1:0] tone;
  logic [VOL_W-1:0]      level [NUM_VOICES];
  logic [SAMPLE_W-1:0]   sum_d;

  assign tone = {voice1_i, voice0_i};

  duo_mixer_volreg #(.W(REG_W)) u_volreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .vol_o     (vol_q)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    duo_mixer_gate #(.VOL_W(VOL_W)) u_gate (
      .tone_i  (tone[v]),
      .vol_i   (vol_q[v*VOL_W +: VOL_W]),
      .level_o (level[v])
    );
  end

  always_comb begin
    sum_d = '0;
    for (int v = 0; v < NUM_VOICES; v++) sum_d = sum_d + SAMPLE_W'(level[v]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= sum_d;
  end
endmodule

// File: rtl/duo_mixer_checker.sv
module duo_mixer_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [5:0] wr_data_i,
  input logic       voice0_i,
  input logic       voice1_i,
  input logic [5:0] vol_q,
  input logic [3:0] sample_o
);
  logic seen_edge;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_edge <= 1'b0;
    else         seen_edge <= 1'b1;

  always_comb
    if (!rst_ni) assert_reset_clear_R1: assert (sample_o == 4'd0 && vol_q == 6'd0);

  assert_write_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vol_q == $past(wr_data_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(vol_q));

  // R4/R5/R6: registered gated sum, compared one cycle later
  assert_sum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_edge |=> sample_o == ($past(voice0_i) ? {1'b0, $past(vol_q[2:0])} : 4'd0)
                            + ($past(voice1_i) ? {1'b0, $past(vol_q[5:3])} : 4'd0));

  assert_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!voice0_i && !voice1_i) |=> sample_o == 4'd0);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o <= 4'd14);
endmodule

bind duo_mixer duo_mixer_checker u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .voice0_i  (voice0_i),
  .voice1_i  (voice1_i),
  .vol_q     (vol_q),
  .sample_o  (sample_o)
);

// File: tb/duo_mixer_tb_top.sv
module duo_mixer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic       v0 = 1'b0, v1 = 1'b0;
  logic [3:0] sample;
  int checks = 0, fails = 0;
  logic [5:0] vol_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duo_mixer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .voice0_i(v0), .voice1_i(v1), .sample_o(sample)
  );

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (sample !== exp) begin
      fails++;
      $display("FAIL %s: sample=%0d expected=%0d", req, sample, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic a, input logic b, input logic [5:0] vol);
    return (a ? {1'b0, vol[2:0]} : 4'd0) + (b ? {1'b0, vol[5:3]} : 4'd0);
  endfunction

  // inputs change on falling edge; output sampled on the next falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_vol(input logic [5:0] d);
    wr_en = 1'b1; wr_data = d; vol_model = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_voices(input logic a, input logic b);
    v0 = a; v1 = b;
    step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset sample", 4'd0);
    rst_n = 1'b1;
    set_voices(1, 1);
    check("R1 reset volumes zero", 4'd0);
  endtask

  task automatic t_write_fields();
    set_voices(1, 0);
    write_vol({3'd2, 3'd5});
    step();
    check("R2 voice0 field [2:0]", 4'd5);
    set_voices(0, 1);
    check("R2 voice1 field [5:3]", 4'd2);
  endtask

  task automatic t_hold();
    wr_data = 6'b111_111;
    set_voices(1, 1);
    check("R3 no write keeps volume", model(1, 1, vol_model));
    wr_data = 6'd0;
    step();
    check("R3 no write keeps volume again", 4'd7);
  endtask

  task automatic t_gating();
    write_vol({3'd6, 3'd3});
    for (int p = 0; p < 4; p++) begin
      set_voices(p[0], p[1]);
      check("R4 gating pattern", model(p[0], p[1], vol_model));
    end
    write_vol({3'd0, 3'd7});
    set_voices(1, 1);
    check("R4 zero level silences voice1", 4'd7);
  endtask

  task automatic t_max();
    write_vol(6'b111_111);
    set_voices(1, 1);
    check("R5 full sum 14", 4'd14);
    check("R7 bound", sample <= 4'd14 ? sample : 4'd14);
  endtask

  task automatic t_latency();
    write_vol({3'd4, 3'd1});
    set_voices(0, 0);
    v0 = 1'b1; v1 = 1'b1;
    @(posedge clk); #1;
    check("R6 updates at first edge after change", 4'd5);
    @(negedge clk);
    v0 = 1'b0;
    #1;
    check("R6 no change before edge", 4'd5);
    step();
    check("R6 after edge", 4'd4);
    wr_en = 1'b1; wr_data = {3'd1, 3'd0}; vol_model = wr_data;
    @(posedge clk); #1;
    check("R6 write then old volume used for this sample", 4'd4);
    @(negedge clk); wr_en = 1'b0;
    step();
    check("R6 new volume one cycle after write", 4'd1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_fields();
        t_hold();
        t_gating();
        t_max();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule